// File: doc/BRIEF.md
# Load Memory Admission and Blocked-Load Arbiter

This block sits after the store-forwarding check of a load/store unit. For each load that was not satisfied by forwarding, it decides within the same cycle what happens next. The load is either sent to the data cache, sent back for rescheduling, faulted, or recorded as blocked because the cache is busy. A blocked load forces a pipeline restart from that load.

Loads that bypass the cache are only let through when they are both at the head of the load queue and ready to commit. Every other such load is rescheduled and flagged with a fault indication. A cacheable load goes out on a request/accept port tagged with its queue index and a load marker. A refusal that reports a bad address raises a machine-check fault. Any other refusal latches a retry flag that carries this thread's identifier, and the cache is then treated as blocked for that load.

The block holds a single blocked-load record: a blocked flag, a handled flag and a sequence number. The record always describes the oldest load that found the cache busy. A restart request is raised while the load is blocked and not yet handled. An upstream controller acknowledges the restart by setting the handled flag and later clears the blocked flag. Sequence numbers are compared as plain unsigned values. Wraparound is not handled.

Top module: `ld_mem_gate`

## Requirements
- R1: A valid load with `ld_uncached`=1 that is not both `ld_at_head`=1 and `ld_at_commit`=1 issues no cache request. In the same cycle it drives `ld_resched`=1 and `ld_fault`=1, and it does not touch the blocked record.
- R2: A valid uncached load that is both at the head and at commit is handled exactly like a cacheable load.
- R3: An admitted load issues `mem_req_valid`=1 in the same cycle when `cache_blocked`=0. The tag `mem_req_tag` carries the load marker 1 in its most significant bit and `ld_idx` in the bits below it.
- R4: If a request is refused (`cache_accept`=0) with `cache_bad_addr`=1, the block drives `ld_fault`=1 in that cycle. It records no blocked load and sets no retry flag.
- R5: A refusal without bad address sets `retry_pend` on the next cycle, with `retry_tid` equal to the parameter THREAD_ID (and 0 while not pending). A `cache_retry` pulse clears the flag, and a new refusal in the same cycle wins.
- R6: An admitted load that meets `cache_blocked`=1 issues no request, or has its request refused without bad address. In both cases `ld_blocked_now`=1 unless R8 applies. `ld_fault` stays 0 for it.
- R7: Recording a blocked load gives, on the next cycle, `blk_flag`=1, `blk_handled`=0 and `blk_seq` equal to the load's `ld_seq`.
- R8: If `blk_flag`=1 and the stored sequence number is strictly smaller than the new load's, the new blocked load is ignored. The record is unchanged, `ld_blocked_now`=0 and `ld_fault`=0.
- R9: A blocked load whose `ld_seq` is less than or equal to the stored one replaces the record.
- R10: `ctl_set_handled` sets `blk_handled` and `ctl_clr_blocked` clears `blk_flag` on the next cycle. A recording in the same cycle takes priority over both. `restart_req` is 1 exactly while `blk_flag`=1 and `blk_handled`=0, and `restart_seq` equals `blk_seq`.
- R11: After reset, `blk_flag`, `blk_handled`, `blk_seq`, `restart_req` and `retry_pend` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | A load leaves the forwarding check this cycle |
| ld_idx | input | IDX_W | Load-queue index of the load |
| ld_seq | input | SEQ_W | Sequence number of the load |
| ld_uncached | input | 1 | Load bypasses the cache |
| ld_at_head | input | 1 | Load is at the load-queue head |
| ld_at_commit | input | 1 | Load is ready to commit |
| cache_blocked | input | 1 | Cache is currently blocked |
| cache_accept | input | 1 | Cache accepts the request this cycle |
| cache_bad_addr | input | 1 | Refusal reason is a bad address |
| cache_retry | input | 1 | Cache signals it can take a retry |
| ctl_set_handled | input | 1 | Controller marks the blocked load handled |
| ctl_clr_blocked | input | 1 | Controller clears the blocked flag |
| mem_req_valid | output | 1 | Load request to the cache |
| mem_req_tag | output | IDX_W+1 | {load marker, load index} |
| ld_resched | output | 1 | Load must be rescheduled |
| ld_fault | output | 1 | Fault indication for the load |
| ld_blocked_now | output | 1 | Load is recorded as blocked this cycle |
| blk_flag | output | 1 | Blocked flag |
| blk_handled | output | 1 | Handled flag |
| blk_seq | output | SEQ_W | Sequence number of the blocked load |
| restart_req | output | 1 | Pipeline restart request |
| restart_seq | output | SEQ_W | Sequence number to restart from |
| retry_pend | output | 1 | Retry flag for this thread |
| retry_tid | output | TID_W | Thread awaiting the retry |

## Verification
The assertions check several rules on every cycle. A speculative uncached load never reaches the cache. A bad-address refusal always faults. A recording always gives a set, unhandled record with the load's sequence number. An ignored younger load leaves the record stable. A rise of the restart request always follows a recording. A non-bad refusal always leaves the retry flag set. Three things only the bench scenarios can show: the choice between replacing and keeping the record for chosen age orderings, the priority of recording over the controller's set and clear in one cycle, and the exact tag and fault values across random mixes of head, commit, block and refusal inputs.

// File: rtl/ldg_pkg.sv
// ldg_pkg: shared types of the load memory admission arbiter.
// Assumes sequence numbers are plain unsigned values without wraparound.
package ldg_pkg;

    // Outcome of one load in the admission stage
    typedef enum logic [1:0] {
        DEC_IDLE    = 2'd0,  // no load this cycle
        DEC_SEND    = 2'd1,  // request goes to the cache
        DEC_RESCHED = 2'd2,  // speculative uncached load sent back
        DEC_HOLD    = 2'd3   // cache busy, no request issued
    } ldg_dec_e;

    // True when sequence number a is strictly older than b
    function automatic logic seq_older(input logic [63:0] a, input logic [63:0] b);
        return a < b;
    endfunction

endpackage

// File: rtl/ldg_admit.sv
// ldg_admit: classifies a load as send, reschedule or hold and resolves
// the cache's answer into fault, retry and busy events in the same cycle.
// Assumes cache_accept/cache_bad_addr are meaningful only while a request
// is presented; they are ignored otherwise.
module ldg_admit
    import ldg_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             ld_valid,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic             ld_uncached,
    input  logic             ld_at_head,
    input  logic             ld_at_commit,
    input  logic             cache_blocked,
    input  logic             cache_accept,
    input  logic             cache_bad_addr,
    output ldg_dec_e         dec,
    output logic             req_valid,
    output logic [IDX_W:0]   req_tag,
    output logic             resched,
    output logic             fault,
    output logic             refuse_retry,
    output logic             busy_evt
);

    localparam logic LOAD_MARK = 1'b1;

    logic non_spec;
    logic refused;

    // Decide the path of the load from its kind and the cache state
    always_comb begin
        non_spec = ld_at_head & ld_at_commit;
        if (!ld_valid)
            dec = DEC_IDLE;
        else if (ld_uncached && !non_spec)
            dec = DEC_RESCHED;
        else if (cache_blocked)
            dec = DEC_HOLD;
        else
            dec = DEC_SEND;
    end

    // Drive the request and resolve the cache's answer
    always_comb begin
        req_valid    = (dec == DEC_SEND);
        req_tag      = {LOAD_MARK, ld_idx};
        refused      = req_valid & ~cache_accept;
        resched      = (dec == DEC_RESCHED);
        fault        = resched | (refused & cache_bad_addr);
        refuse_retry = refused & ~cache_bad_addr;
        busy_evt     = (dec == DEC_HOLD) | refuse_retry;
    end

endmodule

// File: rtl/ldg_block_rec.sv
// ldg_block_rec: the single blocked-load record. It keeps the oldest load
// that met a busy cache, with a handled flag for the upstream controller.
// Assumes at most one busy event per cycle.
module ldg_block_rec
    import ldg_pkg::*;
#(
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy_evt,
    input  logic [SEQ_W-1:0] ld_seq,
    input  logic             ctl_set_handled,
    input  logic             ctl_clr_blocked,
    output logic             record,
    output logic             blk_flag,
    output logic             blk_handled,
    output logic [SEQ_W-1:0] blk_seq
);

    logic keep_old;

    // Ignore a new busy load when an older one is already recorded
    always_comb begin
        keep_old = blk_flag && seq_older(64'(blk_seq), 64'(ld_seq));
        record   = busy_evt & ~keep_old;
    end

    // Record state; a new recording overrides the controller's requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_flag    <= 1'b0;
            blk_handled <= 1'b0;
            blk_seq     <= '0;
        end else if (record) begin
            blk_flag    <= 1'b1;
            blk_handled <= 1'b0;
            blk_seq     <= ld_seq;
        end else begin
            if (ctl_clr_blocked) blk_flag    <= 1'b0;
            if (ctl_set_handled) blk_handled <= 1'b1;
        end
    end

    // R7: a recording leaves a set, unhandled record holding the load
    a_r7_record_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && record) |=> (blk_flag && !blk_handled && blk_seq == $past(ld_seq)));

    // R8: an ignored younger busy load leaves the sequence number alone
    a_r8_older_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && busy_evt && !record) |=> $stable(blk_seq));

endmodule

// File: rtl/ldg_retry_latch.sv
// ldg_retry_latch: remembers that this thread is waiting for a cache retry.
// Assumes the cache pulses cache_retry when it can take the access again.
module ldg_retry_latch #(
    parameter int TID_W     = 2,
    parameter int THREAD_ID = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             refuse_retry,
    input  logic             cache_retry,
    output logic             retry_pend,
    output logic [TID_W-1:0] retry_tid
);

    localparam logic [TID_W-1:0] MY_TID = TID_W'(THREAD_ID);

    // Set on a non-bad refusal, cleared by the retry pulse, set wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            retry_pend <= 1'b0;
        else if (refuse_retry)
            retry_pend <= 1'b1;
        else if (cache_retry)
            retry_pend <= 1'b0;
    end

    // Present the thread identifier only while a retry is owed
    always_comb retry_tid = retry_pend ? MY_TID : '0;

    // R5: a non-bad refusal always leaves the retry flag set
    a_r5_retry_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && refuse_retry) |=> (retry_pend && retry_tid == MY_TID));

endmodule

// File: rtl/ld_mem_gate.sv
// ld_mem_gate: admission arbiter for loads leaving the forwarding check.
// It sends, reschedules or faults each load, keeps the oldest blocked
// load and raises a restart request until the controller handles it.
// Assumes one load per cycle and a cache that answers in the same cycle.
module ld_mem_gate
    import ldg_pkg::*;
#(
    parameter int LQ_DEPTH  = 16,
    parameter int SEQ_W     = 16,
    parameter int TID_W     = 2,
    parameter int THREAD_ID = 1,
    localparam int IDX_W    = $clog2(LQ_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_valid,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [SEQ_W-1:0] ld_seq,
    input  logic             ld_uncached,
    input  logic             ld_at_head,
    input  logic             ld_at_commit,
    input  logic             cache_blocked,
    input  logic             cache_accept,
    input  logic             cache_bad_addr,
    input  logic             cache_retry,
    input  logic             ctl_set_handled,
    input  logic             ctl_clr_blocked,
    output logic             mem_req_valid,
    output logic [IDX_W:0]   mem_req_tag,
    output logic             ld_resched,
    output logic             ld_fault,
    output logic             ld_blocked_now,
    output logic             blk_flag,
    output logic             blk_handled,
    output logic [SEQ_W-1:0] blk_seq,
    output logic             restart_req,
    output logic [SEQ_W-1:0] restart_seq,
    output logic             retry_pend,
    output logic [TID_W-1:0] retry_tid
);

    ldg_dec_e dec;
    logic     refuse_retry;
    logic     busy_evt;
    logic     record;

    ldg_admit #(.IDX_W(IDX_W)) u_admit (
        .ld_valid       (ld_valid),
        .ld_idx         (ld_idx),
        .ld_uncached    (ld_uncached),
        .ld_at_head     (ld_at_head),
        .ld_at_commit   (ld_at_commit),
        .cache_blocked  (cache_blocked),
        .cache_accept   (cache_accept),
        .cache_bad_addr (cache_bad_addr),
        .dec            (dec),
        .req_valid      (mem_req_valid),
        .req_tag        (mem_req_tag),
        .resched        (ld_resched),
        .fault          (ld_fault),
        .refuse_retry   (refuse_retry),
        .busy_evt       (busy_evt)
    );

    ldg_block_rec #(.SEQ_W(SEQ_W)) u_rec (
        .clk             (clk),
        .rst_n           (rst_n),
        .busy_evt        (busy_evt),
        .ld_seq          (ld_seq),
        .ctl_set_handled (ctl_set_handled),
        .ctl_clr_blocked (ctl_clr_blocked),
        .record          (record),
        .blk_flag        (blk_flag),
        .blk_handled     (blk_handled),
        .blk_seq         (blk_seq)
    );

    ldg_retry_latch #(.TID_W(TID_W), .THREAD_ID(THREAD_ID)) u_retry (
        .clk          (clk),
        .rst_n        (rst_n),
        .refuse_retry (refuse_retry),
        .cache_retry  (cache_retry),
        .retry_pend   (retry_pend),
        .retry_tid    (retry_tid)
    );

    // Restart is owed while a blocked load waits for the controller
    always_comb begin
        restart_req    = blk_flag & ~blk_handled;
        restart_seq    = blk_seq;
        ld_blocked_now = record;
    end

    // R1: a speculative uncached load never reaches the cache
    a_r1_no_spec_uncached: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_uncached && !(ld_at_head && ld_at_commit)) |-> (!mem_req_valid && ld_resched));

    // R4: a bad-address refusal always faults and never blocks
    a_r4_bad_addr_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !cache_accept && cache_bad_addr) |-> (ld_fault && !ld_blocked_now));

    // R10: a new restart request always follows a recording
    a_r10_restart_source: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $rose(restart_req)) |-> $past(ld_blocked_now));

    // R6: a held load never carries a fault
    a_r6_hold_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (dec == DEC_HOLD) |-> !ld_fault);

endmodule

// File: tb/tb_ld_mem_gate.sv
`timescale 1ns/1ps
module tb_ld_mem_gate;

    localparam int LQ_DEPTH  = 16;
    localparam int SEQ_W     = 16;
    localparam int TID_W     = 2;
    localparam int THREAD_ID = 1;
    localparam int IDX_W     = $clog2(LQ_DEPTH);

    logic             clk = 1'b0;
    logic             rst_n;
    logic             ld_valid, ld_uncached, ld_at_head, ld_at_commit;
    logic [IDX_W-1:0] ld_idx;
    logic [SEQ_W-1:0] ld_seq;
    logic             cache_blocked, cache_accept, cache_bad_addr, cache_retry;
    logic             ctl_set_handled, ctl_clr_blocked;
    logic             mem_req_valid, ld_resched, ld_fault, ld_blocked_now;
    logic [IDX_W:0]   mem_req_tag;
    logic             blk_flag, blk_handled, restart_req, retry_pend;
    logic [SEQ_W-1:0] blk_seq, restart_seq;
    logic [TID_W-1:0] retry_tid;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // Bench model state
    logic             m_blk, m_hnd, m_retry;
    logic [SEQ_W-1:0] m_seq;

    always #2.5 clk = ~clk;

    ld_mem_gate #(.LQ_DEPTH(LQ_DEPTH), .SEQ_W(SEQ_W), .TID_W(TID_W),
                  .THREAD_ID(THREAD_ID)) dut (.*);

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit f_spec_unc();
        return ld_valid && ld_uncached && !(ld_at_head && ld_at_commit);
    endfunction
    function automatic bit f_req();
        return ld_valid && !f_spec_unc() && !cache_blocked;
    endfunction
    function automatic bit f_bad();
        return f_req() && !cache_accept && cache_bad_addr;
    endfunction
    function automatic bit f_rfs();
        return f_req() && !cache_accept && !cache_bad_addr;
    endfunction
    function automatic bit f_record();
        bit busy;
        busy = (ld_valid && !f_spec_unc() && cache_blocked) || f_rfs();
        return busy && !(m_blk && m_seq < ld_seq);
    endfunction

    // Compare every output with the model, then advance the model
    task automatic eval_cycle();
        #1;
        chk("R3", "mem_req_valid", mem_req_valid, f_req());
        if (f_req()) chk("R3", "mem_req_tag", mem_req_tag, {1'b1, ld_idx});
        chk("R1", "ld_resched", ld_resched, f_spec_unc());
        chk("R4", "ld_fault", ld_fault, f_spec_unc() || f_bad());
        chk("R6", "ld_blocked_now", ld_blocked_now, f_record());
        chk("R7", "blk_flag", blk_flag, m_blk);
        chk("R10", "blk_handled", blk_handled, m_hnd);
        chk("R8", "blk_seq", blk_seq, m_seq);
        chk("R10", "restart_req", restart_req, m_blk && !m_hnd);
        chk("R10", "restart_seq", restart_seq, m_seq);
        chk("R5", "retry_pend", retry_pend, m_retry);
        chk("R5", "retry_tid", retry_tid, m_retry ? THREAD_ID : 0);
        if (f_record()) begin
            m_blk = 1'b1; m_hnd = 1'b0; m_seq = ld_seq;
        end else begin
            if (ctl_clr_blocked) m_blk = 1'b0;
            if (ctl_set_handled) m_hnd = 1'b1;
        end
        if (f_rfs()) m_retry = 1'b1;
        else if (cache_retry) m_retry = 1'b0;
    endtask

    task automatic idle_inputs();
        ld_valid = 0; ld_idx = '0; ld_seq = '0; ld_uncached = 0;
        ld_at_head = 0; ld_at_commit = 0; cache_blocked = 0; cache_accept = 1;
        cache_bad_addr = 0; cache_retry = 0; ctl_set_handled = 0; ctl_clr_blocked = 0;
    endtask

    // One load: unc, head, commit, blocked, accept, bad
    task automatic load(input logic [SEQ_W-1:0] s, input logic [IDX_W-1:0] ix,
                        input bit unc, input bit hd, input bit cm,
                        input bit cb, input bit acc, input bit bad);
        @(negedge clk);
        idle_inputs();
        ld_valid = 1; ld_seq = s; ld_idx = ix; ld_uncached = unc; ld_at_head = hd;
        ld_at_commit = cm; cache_blocked = cb; cache_accept = acc; cache_bad_addr = bad;
        eval_cycle();
    endtask

    task automatic ctl(input bit sh, input bit cl, input bit rt);
        @(negedge clk);
        idle_inputs();
        ctl_set_handled = sh; ctl_clr_blocked = cl; cache_retry = rt;
        eval_cycle();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        m_blk = 0; m_hnd = 0; m_retry = 0; m_seq = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R11: reset state
        chk("R11", "blk_flag", blk_flag, 0);
        chk("R11", "blk_handled", blk_handled, 0);
        chk("R11", "blk_seq", blk_seq, 0);
        chk("R11", "restart_req", restart_req, 0);
        chk("R11", "retry_pend", retry_pend, 0);

        // R1: speculative uncached loads rescheduled with a fault
        load(16'd5, 4'd3, 1, 0, 1, 0, 1, 0);
        load(16'd6, 4'd4, 1, 1, 0, 0, 1, 0);
        // R2: non-speculative uncached load goes to the cache
        load(16'd7, 4'd9, 1, 1, 1, 0, 1, 0);
        @(negedge clk);
        idle_inputs();
        ld_valid = 1; ld_uncached = 1; ld_at_head = 1; ld_at_commit = 1; ld_idx = 4'd9;
        #1 chk("R2", "uncached at head request", mem_req_valid, 1);
        eval_cycle();
        // R3: plain accepted load
        load(16'd8, 4'd15, 0, 0, 0, 0, 1, 0);
        // R4: bad-address refusal
        load(16'd9, 4'd1, 0, 0, 0, 0, 0, 1);
        ctl(0, 0, 0);
        // R5: other refusal sets retry and records the load
        load(16'd40, 4'd2, 0, 0, 0, 0, 0, 0);
        ctl(0, 0, 0);
        ctl(0, 0, 1);
        ctl(0, 0, 0);
        // R8: younger blocked load ignored
        load(16'd50, 4'd5, 0, 0, 0, 1, 1, 0);
        ctl(0, 0, 0);
        chk("R8", "older record kept", blk_seq, 16'd40);
        // R9: older or equal load replaces the record
        load(16'd40, 4'd6, 0, 0, 0, 1, 1, 0);
        load(16'd30, 4'd6, 0, 0, 0, 1, 1, 0);
        ctl(0, 0, 0);
        chk("R9", "younger record replaced", blk_seq, 16'd30);
        // R10: handled, then clear; record wins over both in one cycle
        ctl(1, 0, 0);
        ctl(0, 1, 0);
        ctl(0, 0, 0);
        @(negedge clk);
        idle_inputs();
        ld_valid = 1; ld_seq = 16'd77; cache_blocked = 1;
        ctl_set_handled = 1; ctl_clr_blocked = 1;
        eval_cycle();
        ctl(0, 0, 0);
        chk("R10", "record priority restart", restart_req, 1);

        // Random mix with fixed seed
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            ld_valid        = ($urandom % 4) != 0;
            ld_idx          = IDX_W'($urandom);
            ld_seq          = SEQ_W'($urandom % 64);
            ld_uncached     = ($urandom % 4) == 0;
            ld_at_head      = $urandom % 2;
            ld_at_commit    = $urandom % 2;
            cache_blocked   = ($urandom % 5) == 0;
            cache_accept    = ($urandom % 3) != 0;
            cache_bad_addr  = ($urandom % 3) == 0;
            cache_retry     = ($urandom % 4) == 0;
            ctl_set_handled = ($urandom % 6) == 0;
            ctl_clr_blocked = ($urandom % 8) == 0;
            eval_cycle();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule